// File: doc/BRIEF.md
# Fetch Redirect Epoch Controller

This block owns the speculative state of a six-stage instruction front end. Three sources may steer fetch away from the sequential path. The first is a fast predictor stage. The second is a slower, more accurate predictor stage. The third is branch resolution in execute. The block keeps one 1-bit epoch per source and exposes the three bits as a tag. Fetch stamps that tag on every instruction it issues. When a source redirects, the block flips that source's epoch and loads the new fetch address. Instructions still in flight that carry the old value are then recognised as wrong-path work.

Each cycle the block takes all redirect requests. It discards any request whose own tag is already stale, then keeps the accepted request from the deepest stage. That winner sets the fetch PC register, so the redirected address is fetched on the very next cycle. With no winner, fetch follows the target-buffer prediction when one is offered, and the next sequential address otherwise. For every stage up to execute, the block also reports whether the instruction currently held there must be discarded. This drop signal is combinational in the same cycle.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: While `rst_n` is low, `fetch_pc_o` equals the parameter `RESET_PC` and `fetch_tag_o` is 3'b000.
- R2: In a cycle with no accepted redirect and `btb_hit_i` low, `fetch_pc_o` advances by `PC_STEP` (default 4) at the next clock edge.
- R3: In a cycle with no accepted redirect and `btb_hit_i` high, `fetch_pc_o` takes `btb_target_i` at the next clock edge.
- R4: An accepted redirect loads its target into `fetch_pc_o` at the next edge. It inverts exactly one epoch bit: bit 0 for the fast predictor, bit 1 for the slow predictor, bit 2 for execute.
- R5: When more than one request is accepted in a cycle, the deepest one wins: execute over slow predictor, and slow predictor over fast predictor.
- R6: A request is accepted only if its tag equals the current epochs at its own bit and at every deeper bit. Fast uses bits 2..0, slow uses bits 2..1, and execute uses bit 2. A rejected request changes neither the PC nor the epochs.
- R7: `drop_o[s]` is high in the same cycle when `stage_vld_i[s]` is high and the tag slice `stage_tag_i[3*s+2:3*s]` differs from the current epochs in a checked bit. Bit 0 is checked for s <= FAST_STG (1). Bit 1 is checked for s <= SLOW_STG (2). Bit 2 is checked for s <= EXEC_STG (4). The last stage is never dropped.
- R8: `fetch_tag_o` always shows the current epochs, {exec, slow, fast}.
- R9: An accepted redirect overrides a target-buffer prediction offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btb_hit_i | input | 1 | Target buffer offers a prediction for the current fetch |
| btb_target_i | input | PC_W | Predicted next fetch address |
| fast_req_i | input | 1 | Fast predictor redirect request |
| fast_target_i | input | PC_W | Fast predictor redirect address |
| fast_tag_i | input | 3 | Epoch tag of the fast-stage instruction |
| slow_req_i | input | 1 | Slow predictor redirect request |
| slow_target_i | input | PC_W | Slow predictor redirect address |
| slow_tag_i | input | 3 | Epoch tag of the slow-stage instruction |
| exec_req_i | input | 1 | Branch resolution redirect request |
| exec_target_i | input | PC_W | Resolved branch address |
| exec_tag_i | input | 3 | Epoch tag of the executing instruction |
| stage_vld_i | input | N_STAGES | Per-stage valid |
| stage_tag_i | input | 3*N_STAGES | Per-stage epoch tags, stage s at bits 3s+2..3s |
| fetch_pc_o | output | PC_W | Address fetched this cycle |
| fetch_tag_o | output | 3 | Epoch tag to stamp on the fetched instruction |
| drop_o | output | N_STAGES | Per-stage discard indication |

## Verification
The in-RTL assertions check these on every cycle: the PC step when nothing redirects, the load of the winning target, the single-bit epoch flip after a grant, epoch stability when nothing is granted, and the precedence of an accepted execute request. The bench scenarios are needed to show the rest. This covers stale requests being rejected at each level, and a stale deep request letting a shallower valid one win. It also covers the per-stage masking of the drop comparison, and a redirect beating a target-buffer hit in the same cycle.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam int NLVL = 3;

  typedef enum logic [1:0] {
    LVL_FAST = 2'd0,
    LVL_SLOW = 2'd1,
    LVL_EXEC = 2'd2
  } lvl_e;

  typedef logic [NLVL-1:0] epoch_t;

  // Bits compared for a request from level lvl: its own and all deeper ones.
  function automatic epoch_t accept_mask(int lvl);
    epoch_t m;
    for (int b = 0; b < NLVL; b++) m[b] = (b >= lvl);
    return m;
  endfunction

  // Bits compared for an instruction sitting in stage s.
  function automatic epoch_t stage_mask(int s, int fast_stg, int slow_stg, int exec_stg);
    epoch_t m;
    m[0] = (s <= fast_stg);
    m[1] = (s <= slow_stg);
    m[2] = (s <= exec_stg);
    return m;
  endfunction
endpackage

// File: rtl/redir_arbiter.sv
module redir_arbiter
  import redir_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [NLVL-1:0]           req_i,
  input  logic [NLVL-1:0][NLVL-1:0] tag_i,
  input  logic [NLVL-1:0][PC_W-1:0] tgt_i,
  input  epoch_t                    cur_ep_i,
  output logic [NLVL-1:0]           accept_o,
  output logic                      win_vld_o,
  output lvl_e                      win_lvl_o,
  output logic [PC_W-1:0]           win_tgt_o
);
  // Per-level staleness filter
  for (genvar l = 0; l < NLVL; l++) begin : g_acc
    localparam epoch_t MASK = accept_mask(l);
    assign accept_o[l] = req_i[l] && (((tag_i[l] ^ cur_ep_i) & MASK) == '0);
  end

  // Deeper levels are visited last and therefore win
  always_comb begin
    win_vld_o = 1'b0;
    win_lvl_o = LVL_FAST;
    win_tgt_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (accept_o[l]) begin
        win_vld_o = 1'b1;
        win_lvl_o = lvl_e'(l);
        win_tgt_o = tgt_i[l];
      end
    end
  end
endmodule

// File: rtl/redir_state.sv
module redir_state
  import redir_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_vld_i,
  input  lvl_e            win_lvl_i,
  input  logic [PC_W-1:0] win_tgt_i,
  input  logic            btb_hit_i,
  input  logic [PC_W-1:0] btb_tgt_i,
  output logic [PC_W-1:0] pc_o,
  output epoch_t          ep_o
);
  localparam logic [PC_W-1:0] STEP_V  = PC_W'(PC_STEP);
  localparam logic [PC_W-1:0] RESET_V = PC_W'(RESET_PC);

  logic [PC_W-1:0] pc_q, pc_d;
  epoch_t          ep_q, ep_d;
  logic            upd_en;

  // Next-state: redirect first, then target buffer, then sequential
  always_comb begin
    upd_en = 1'b1;
    ep_d   = ep_q;
    if (win_vld_i) begin
      ep_d[win_lvl_i] = ~ep_q[win_lvl_i];
      pc_d            = win_tgt_i;
    end else if (btb_hit_i) begin
      pc_d = btb_tgt_i;
    end else begin
      pc_d = pc_q + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_V;
      ep_q <= '0;
    end else if (upd_en) begin
      pc_q <= pc_d;
      ep_q <= ep_d;
    end
  end

  assign pc_o = pc_q;
  assign ep_o = ep_q;

  // R4
  ep_one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_i |=> $countones(ep_q ^ $past(ep_q)) == 1);

  // R6
  ep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld_i |=> $stable(ep_q));

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_vld_i && !btb_hit_i) |=> pc_q == $past(pc_q) + STEP_V);
endmodule

// File: rtl/stage_drop.sv
module stage_drop
  import redir_pkg::*;
#(
  parameter int N_STAGES = 6,
  parameter int FAST_STG = 1,
  parameter int SLOW_STG = 2,
  parameter int EXEC_STG = 4
) (
  input  logic [N_STAGES-1:0]      vld_i,
  input  logic [N_STAGES*NLVL-1:0] tag_i,
  input  epoch_t                   cur_ep_i,
  output logic [N_STAGES-1:0]      drop_o
);
  for (genvar s = 0; s < N_STAGES; s++) begin : g_stg
    if (s > EXEC_STG) begin : g_commit
      // Past execute nothing is speculative
      assign drop_o[s] = 1'b0;
    end else begin : g_spec
      localparam epoch_t MASK = stage_mask(s, FAST_STG, SLOW_STG, EXEC_STG);
      epoch_t tag_s;
      assign tag_s     = tag_i[s*NLVL +: NLVL];
      assign drop_o[s] = vld_i[s] && (((tag_s ^ cur_ep_i) & MASK) != '0);
    end
  end
endmodule

// File: rtl/fetch_redirect_ctrl.sv
module fetch_redirect_ctrl
  import redir_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          PC_STEP  = 4,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter int          N_STAGES = 6,
  parameter int          FAST_STG = 1,
  parameter int          SLOW_STG = 2,
  parameter int          EXEC_STG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      btb_hit_i,
  input  logic [PC_W-1:0]           btb_target_i,
  input  logic                      fast_req_i,
  input  logic [PC_W-1:0]           fast_target_i,
  input  logic [2:0]                fast_tag_i,
  input  logic                      slow_req_i,
  input  logic [PC_W-1:0]           slow_target_i,
  input  logic [2:0]                slow_tag_i,
  input  logic                      exec_req_i,
  input  logic [PC_W-1:0]           exec_target_i,
  input  logic [2:0]                exec_tag_i,
  input  logic [N_STAGES-1:0]       stage_vld_i,
  input  logic [3*N_STAGES-1:0]     stage_tag_i,
  output logic [PC_W-1:0]           fetch_pc_o,
  output logic [2:0]                fetch_tag_o,
  output logic [N_STAGES-1:0]       drop_o
);
  logic [NLVL-1:0]           req;
  logic [NLVL-1:0][NLVL-1:0] tag;
  logic [NLVL-1:0][PC_W-1:0] tgt;
  logic [NLVL-1:0]           accept;
  logic                      win_vld;
  lvl_e                      win_lvl;
  logic [PC_W-1:0]           win_tgt;
  epoch_t                    cur_ep;

  assign req = {exec_req_i, slow_req_i, fast_req_i};
  assign tag = {exec_tag_i, slow_tag_i, fast_tag_i};
  assign tgt = {exec_target_i, slow_target_i, fast_target_i};

  redir_arbiter #(.PC_W(PC_W)) u_arb (
    .req_i     (req),
    .tag_i     (tag),
    .tgt_i     (tgt),
    .cur_ep_i  (cur_ep),
    .accept_o  (accept),
    .win_vld_o (win_vld),
    .win_lvl_o (win_lvl),
    .win_tgt_o (win_tgt)
  );

  redir_state #(.PC_W(PC_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_vld_i (win_vld),
    .win_lvl_i (win_lvl),
    .win_tgt_i (win_tgt),
    .btb_hit_i (btb_hit_i),
    .btb_tgt_i (btb_target_i),
    .pc_o      (fetch_pc_o),
    .ep_o      (cur_ep)
  );

  stage_drop #(.N_STAGES(N_STAGES), .FAST_STG(FAST_STG),
               .SLOW_STG(SLOW_STG), .EXEC_STG(EXEC_STG)) u_drop (
    .vld_i    (stage_vld_i),
    .tag_i    (stage_tag_i),
    .cur_ep_i (cur_ep),
    .drop_o   (drop_o)
  );

  assign fetch_tag_o = cur_ep;

  // R4 R9
  tgt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |=> fetch_pc_o == $past(win_tgt));

  // R5
  exec_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req_i && exec_tag_i[2] == fetch_tag_o[2]) |=> fetch_pc_o == $past(exec_target_i));

  // R6
  stale_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept[LVL_EXEC] && !accept[LVL_SLOW] && !accept[LVL_FAST]) |=> $stable(fetch_tag_o));
endmodule

// File: tb/sim_fetch_redirect_ctrl.sv
module sim_fetch_redirect_ctrl;
  localparam int PC_W = 32;
  localparam int NS   = 6;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btb_hit_i;
  logic [PC_W-1:0] btb_target_i, fast_target_i, slow_target_i, exec_target_i;
  logic fast_req_i, slow_req_i, exec_req_i;
  logic [2:0] fast_tag_i, slow_tag_i, exec_tag_i;
  logic [NS-1:0] stage_vld_i;
  logic [3*NS-1:0] stage_tag_i;
  logic [PC_W-1:0] fetch_pc_o;
  logic [2:0] fetch_tag_o;
  logic [NS-1:0] drop_o;

  int checks = 0;
  int fails = 0;
  logic [PC_W-1:0] pc_m;
  logic [2:0] ep_m;

  always #2 clk = ~clk;

  fetch_redirect_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic drop_exp(int s, logic v, logic [2:0] t, logic [2:0] e);
    logic [2:0] m;
    m = {s <= 4, s <= 2, s <= 1};
    return v && (((t ^ e) & m) != 3'b000);
  endfunction

  function automatic logic acc_exp(int l, logic r, logic [2:0] t, logic [2:0] e);
    logic [2:0] m;
    m = {1'b1, l <= 1, l == 0};
    return r && (((t ^ e) & m) == 3'b000);
  endfunction

  task automatic clear_in();
    btb_hit_i = 0; btb_target_i = '0;
    fast_req_i = 0; slow_req_i = 0; exec_req_i = 0;
    fast_target_i = '0; slow_target_i = '0; exec_target_i = '0;
    fast_tag_i = ep_m; slow_tag_i = ep_m; exec_tag_i = ep_m;
    stage_vld_i = '0; stage_tag_i = '0;
  endtask

  // Inputs are already driven just after a falling edge
  task automatic run_cycle();
    logic a0, a1, a2, any_req;
    string why;
    #1;
    for (int s = 0; s < NS; s++)
      chk("R7", drop_o[s], drop_exp(s, stage_vld_i[s], stage_tag_i[3*s +: 3], ep_m));
    a0 = acc_exp(0, fast_req_i, fast_tag_i, ep_m);
    a1 = acc_exp(1, slow_req_i, slow_tag_i, ep_m);
    a2 = acc_exp(2, exec_req_i, exec_tag_i, ep_m);
    any_req = fast_req_i | slow_req_i | exec_req_i;
    if (a2) begin
      pc_m = exec_target_i; ep_m[2] = ~ep_m[2];
    end else if (a1) begin
      pc_m = slow_target_i; ep_m[1] = ~ep_m[1];
    end else if (a0) begin
      pc_m = fast_target_i; ep_m[0] = ~ep_m[0];
    end else if (btb_hit_i) begin
      pc_m = btb_target_i;
    end else begin
      pc_m = pc_m + 4;
    end
    if ((a0 | a1 | a2) && btb_hit_i) why = "R9";
    else if ((a0 + a1 + a2) > 1) why = "R5";
    else if (a0 | a1 | a2) why = "R4";
    else if (any_req) why = "R6";
    else if (btb_hit_i) why = "R3";
    else why = "R2";
    @(negedge clk);
    chk(why, fetch_pc_o, pc_m);
    chk("R8", {29'd0, fetch_tag_o}, {29'd0, ep_m});
  endtask

  function automatic logic [2:0] pick_tag(logic [2:0] e);
    return ($urandom % 4 == 0) ? 3'($urandom) : e;
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    pc_m = RPC; ep_m = 3'b000;
    clear_in();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", fetch_pc_o, RPC);
    chk("R1", {29'd0, fetch_tag_o}, 32'd0);
    rst_n = 1'b1;

    // R2 sequential
    clear_in(); run_cycle();
    // R3 target buffer
    clear_in(); btb_hit_i = 1; btb_target_i = 32'h0000_2000; run_cycle();
    // R5 all three valid: execute wins
    clear_in(); fast_req_i = 1; slow_req_i = 1; exec_req_i = 1;
    fast_target_i = 32'hA0; slow_target_i = 32'hB0; exec_target_i = 32'hC0;
    run_cycle();
    // R6 stale execute lets slow win; R9 over target buffer
    clear_in(); exec_req_i = 1; exec_tag_i = ep_m ^ 3'b100; exec_target_i = 32'hC4;
    slow_req_i = 1; slow_target_i = 32'hB4; btb_hit_i = 1; btb_target_i = 32'hD0;
    run_cycle();
    // R6 fast request stale in its own bit is ignored
    clear_in(); fast_req_i = 1; fast_tag_i = ep_m ^ 3'b001; fast_target_i = 32'hA8;
    run_cycle();
    // R6 slow request stale in the execute bit is ignored
    clear_in(); slow_req_i = 1; slow_tag_i = ep_m ^ 3'b100; slow_target_i = 32'hB8;
    run_cycle();
    // R6 execute ignores fast/slow bits
    clear_in(); exec_req_i = 1; exec_tag_i = ep_m ^ 3'b011; exec_target_i = 32'hCC;
    run_cycle();
    // R7 masking: fast-bit mismatch on every stage
    clear_in(); stage_vld_i = '1;
    for (int s = 0; s < NS; s++) stage_tag_i[3*s +: 3] = ep_m ^ 3'b001;
    run_cycle();
    clear_in(); stage_vld_i = '1;
    for (int s = 0; s < NS; s++) stage_tag_i[3*s +: 3] = ep_m ^ 3'b100;
    run_cycle();

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      clear_in();
      btb_hit_i = ($urandom % 3 == 0); btb_target_i = $urandom & ~32'h3;
      fast_req_i = ($urandom % 5 == 0); fast_target_i = $urandom & ~32'h3;
      slow_req_i = ($urandom % 6 == 0); slow_target_i = $urandom & ~32'h3;
      exec_req_i = ($urandom % 7 == 0); exec_target_i = $urandom & ~32'h3;
      fast_tag_i = pick_tag(ep_m); slow_tag_i = pick_tag(ep_m); exec_tag_i = pick_tag(ep_m);
      stage_vld_i = NS'($urandom);
      for (int s = 0; s < NS; s++) stage_tag_i[3*s +: 3] = pick_tag(ep_m);
      run_cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule